// File: doc/BRIEF.md
# Watchdog Timer with Shared Scaler

This block is a watchdog that counts on its own free-running clock, so it keeps timing while the system clock is gated during sleep. A base counter of configurable width overflows at a fixed rate. One 8-bit scaler sits beside it and is lent to exactly one user: either the watchdog, where it divides the base overflows into a longer time-out, or a general-purpose timer, where it divides the timer's input ticks. A 3-bit ratio field picks the tap, and tap k divides by 2^k.

Clear and sleep-entry commands come from the system clock domain. They cross into the watchdog domain through a request/acknowledge handshake that merges commands arriving while one is in flight, so none is dropped. A time-out crosses back and becomes either a reset request, when the system reports it is awake, or a wake-up request, when it reports it is asleep. An active-low status flag records that a time-out happened, and the next clear or sleep command sets it again. A permanent enable input stops the watchdog entirely.

Top module: `wdt_shared_scaler`

## Requirements
- R1: While reset is held and in the first cycle after it, `rst_req_o`, `wake_req_o` and `tmr_tick_o` are 0 and `tmo_n_o` is 1.
- R2: With `scl_sel_i` = 1 (scaler on the watchdog) and `scl_ratio_i` = k, consecutive time-outs are 2^BASE_W * 2^k watchdog clock cycles apart.
- R3: With `scl_sel_i` = 0 (scaler on the timer), consecutive time-outs are 2^BASE_W watchdog clock cycles apart for any `scl_ratio_i`.
- R4: With `scl_sel_i` = 0 and `scl_ratio_i` = k, starting from a zero scaler, `tmr_tick_o` pulses once for every 2^k pulses on `tmr_src_i`.
- R5: With `scl_sel_i` = 1, every pulse on `tmr_src_i` gives one pulse on `tmr_tick_o`, undivided.
- R6: A time-out while `in_sleep_i` = 0 gives a one-cycle pulse on `rst_req_o` and none on `wake_req_o`.
- R7: A time-out while `in_sleep_i` = 1 gives a one-cycle pulse on `wake_req_o` and none on `rst_req_o`.
- R8: `tmo_n_o` is 0 in the cycle a reset or wake-up request is issued and stays 0 until a clear or sleep command, after which it reads 1 in the next cycle.
- R9: A clear command zeroes the base counter, so clear commands spaced closer than the base period keep any time-out from occurring.
- R10: With `scl_sel_i` = 1, a clear command also zeroes the scaler, so clears spaced between one and two base periods never reach tap 3 (divide by 8).
- R11: With `scl_sel_i` = 0, a clear command leaves the scaler count untouched, so a timer division in progress completes on schedule.
- R12: With `wd_en_i` = 0 the watchdog produces no time-out at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset, system domain (re-synchronized for the watchdog domain) |
| wclk_i | input | 1 | Free-running watchdog clock |
| wd_en_i | input | 1 | Permanent watchdog enable |
| scl_sel_i | input | 1 | Scaler owner: 1 watchdog postscaler, 0 timer prescaler |
| scl_ratio_i | input | 3 | Tap select k, divide by 2^k |
| in_sleep_i | input | 1 | System is in sleep |
| clr_cmd_i | input | 1 | One-cycle clear command |
| slp_cmd_i | input | 1 | One-cycle sleep-entry command |
| tmr_src_i | input | 1 | One-cycle timer source tick |
| rst_req_o | output | 1 | One-cycle device reset request |
| wake_req_o | output | 1 | One-cycle wake-up request |
| tmo_n_o | output | 1 | Time-out status, 0 after a time-out |
| tmr_tick_o | output | 1 | Scaled (or bypassed) timer tick |

## Verification
The bench builds the block with BASE_W = 4 and the default 8-bit scaler, so one base period is 16 watchdog cycles and a tap-5 time-out lands after 512; that keeps several consecutive intervals per ratio, both scaler owners, sleep and awake outcomes, and long clear sequences within a short run. The watchdog clock runs three times slower than the system clock, which exercises the handshake on commands and the pulse crossings in both directions with real synchronizer latency, hence interval checks allow a few cycles of slack.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
// Shared constants for the watchdog with shared scaler.
// Assumes eight scaler taps selected by a 3-bit field.
package wdt_pkg;
    localparam int NTAP        = 8;
    localparam int SEL_W       = $clog2(NTAP);
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/wdt_sync_bus.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a quasi-static configuration vector.
// Assumes the source changes rarely and is stable for several
// destination cycles, so a skewed capture settles within one cycle.
module wdt_sync_bus #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the vector through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wdt_pulse_sync.sv
`timescale 1ns/1ps
// Toggle-based single-pulse crossing between two clock domains.
// Assumes source pulses are spaced further apart than the destination
// needs to see one toggle settle (about STAGES+1 destination cycles).
module wdt_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic              src_tgl;
    logic [STAGES:0]   sync_q;

    // Flip the source toggle on every source pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) src_tgl <= 1'b0;
        else if (src_pulse) src_tgl <= ~src_tgl;
    end

    // Bring the toggle into the destination domain and keep one extra stage.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) sync_q <= '0;
        else sync_q <= {sync_q[STAGES-1:0], src_tgl};
    end

    assign dst_pulse = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/wdt_cmd_xfer.sv
`timescale 1ns/1ps
// Lossless command transfer from the system domain to the watchdog
// domain with a toggle request and a returned acknowledge. Commands that
// arrive while one is in flight are merged into one pending command,
// which is safe because clearing is idempotent.
module wdt_cmd_xfer #(
    parameter int STAGES = 2
) (
    input  logic clk_s,
    input  logic rst_s_n,
    input  logic cmd_i,
    input  logic clk_d,
    input  logic rst_d_n,
    output logic cmd_o
);
    logic              pend_q;
    logic              busy_q;
    logic              req_q;
    logic [STAGES-1:0] ack_sync_q;
    logic [STAGES:0]   req_sync_q;
    logic              ack_d;

    // Launch a pending command when idle, retire it on acknowledge.
    always_ff @(posedge clk_s) begin
        if (!rst_s_n) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            req_q  <= 1'b0;
        end else if (!busy_q && pend_q) begin
            req_q  <= ~req_q;
            busy_q <= 1'b1;
            pend_q <= cmd_i;
        end else begin
            if (cmd_i) pend_q <= 1'b1;
            if (busy_q && (ack_sync_q[STAGES-1] == req_q)) busy_q <= 1'b0;
        end
    end

    // Synchronize the returned acknowledge into the system domain.
    always_ff @(posedge clk_s) begin
        if (!rst_s_n) ack_sync_q <= '0;
        else ack_sync_q <= {ack_sync_q[STAGES-2:0], ack_d};
    end

    // Synchronize the request toggle into the watchdog domain.
    always_ff @(posedge clk_d) begin
        if (!rst_d_n) req_sync_q <= '0;
        else req_sync_q <= {req_sync_q[STAGES-1:0], req_q};
    end

    assign ack_d = req_sync_q[STAGES];
    assign cmd_o = req_sync_q[STAGES] ^ req_sync_q[STAGES-1];
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
// Watchdog base counter and the shared scaler, all in the watchdog clock
// domain. The scaler counts base overflows when lent to the watchdog and
// timer ticks when lent to the timer; tap k fires on every 2^k-th event.
// Assumes SCL_W >= NTAP-1 so every tap has its bits.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int BASE_W = 10,
    parameter int SCL_W  = 8
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             en,
    input  logic             sel_wdt,
    input  logic [SEL_W-1:0] ratio,
    input  logic             clr,
    input  logic             tick,
    output logic             base_ovf,
    output logic             timeout,
    output logic             tmr_pulse
);
    logic [BASE_W-1:0] base_q;
    logic [SCL_W-1:0]  scl_q;
    logic [NTAP-1:0]   tap_hit;
    logic              scl_evt;
    logic              scl_hit;

    // Base counter: held at zero when disabled, zeroed by a clear.
    always_ff @(posedge wclk) begin
        if (!wrst_n) base_q <= '0;
        else if (clr || !en) base_q <= '0;
        else base_q <= base_q + 1'b1;
    end

    assign base_ovf = en && !clr && (&base_q);

    // Tap k is reached when the low k scaler bits are all ones.
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        if (g == 0) begin : g_first
            assign tap_hit[g] = 1'b1;
        end else begin : g_rest
            assign tap_hit[g] = &scl_q[g-1:0];
        end
    end

    assign scl_evt = sel_wdt ? base_ovf : tick;
    assign scl_hit = scl_evt && tap_hit[ratio];

    // Shared scaler: cleared with the watchdog only when lent to it.
    always_ff @(posedge wclk) begin
        if (!wrst_n) scl_q <= '0;
        else if (clr && sel_wdt) scl_q <= '0;
        else if (scl_evt) scl_q <= scl_q + 1'b1;
    end

    assign timeout   = sel_wdt ? scl_hit : base_ovf;
    assign tmr_pulse = !sel_wdt && scl_hit;
endmodule

// File: rtl/wdt_shared_scaler.sv
`timescale 1ns/1ps
// Top of the watchdog with shared scaler. Commands, configuration and
// timer ticks cross from the system domain into the watchdog domain;
// time-outs and scaled timer ticks cross back. The reset/wake decision
// and the status flag live in the system domain.
// Assumes time-outs and timer ticks are spaced several cycles apart in
// both domains, and that configuration changes are rare.
module wdt_shared_scaler
    import wdt_pkg::*;
#(
    parameter int BASE_W = 10,
    parameter int SCL_W  = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wclk_i,
    input  logic             wd_en_i,
    input  logic             scl_sel_i,
    input  logic [SEL_W-1:0] scl_ratio_i,
    input  logic             in_sleep_i,
    input  logic             clr_cmd_i,
    input  logic             slp_cmd_i,
    input  logic             tmr_src_i,
    output logic             rst_req_o,
    output logic             wake_req_o,
    output logic             tmo_n_o,
    output logic             tmr_tick_o
);
    localparam int CFG_W = SEL_W + 2;

    logic [1:0]       wrst_q;
    logic             wrst_n;
    logic             cmd_any;
    logic             cmd_w;
    logic             tick_w;
    logic [CFG_W-1:0] cfg_w;
    logic             cfg_en_w;
    logic             cfg_sel_w;
    logic [SEL_W-1:0] cfg_ratio_w;
    logic             base_ovf_w;
    logic             timeout_w;
    logic             tmr_pulse_w;
    logic             to_evt_s;
    logic             tmr_scaled_s;

    // Re-time the system reset into the watchdog domain.
    always_ff @(posedge wclk_i) begin
        wrst_q <= {wrst_q[0], rst_ni};
    end
    assign wrst_n = wrst_q[1];

    assign cmd_any = clr_cmd_i || slp_cmd_i;

    wdt_cmd_xfer #(.STAGES(SYNC_STAGES)) u_cmd (
        .clk_s   (clk_i),
        .rst_s_n (rst_ni),
        .cmd_i   (cmd_any),
        .clk_d   (wclk_i),
        .rst_d_n (wrst_n),
        .cmd_o   (cmd_w)
    );

    wdt_sync_bus #(
        .W       (CFG_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b0, 1'b1, {SEL_W{1'b1}}})
    ) u_cfg (
        .clk   (wclk_i),
        .rst_n (wrst_n),
        .din   ({wd_en_i, scl_sel_i, scl_ratio_i}),
        .dout  (cfg_w)
    );
    assign {cfg_en_w, cfg_sel_w, cfg_ratio_w} = cfg_w;

    wdt_pulse_sync #(.STAGES(SYNC_STAGES)) u_tick_in (
        .src_clk   (clk_i),
        .src_rst_n (rst_ni),
        .src_pulse (tmr_src_i),
        .dst_clk   (wclk_i),
        .dst_rst_n (wrst_n),
        .dst_pulse (tick_w)
    );

    wdt_core #(.BASE_W(BASE_W), .SCL_W(SCL_W)) u_core (
        .wclk      (wclk_i),
        .wrst_n    (wrst_n),
        .en        (cfg_en_w),
        .sel_wdt   (cfg_sel_w),
        .ratio     (cfg_ratio_w),
        .clr       (cmd_w),
        .tick      (tick_w),
        .base_ovf  (base_ovf_w),
        .timeout   (timeout_w),
        .tmr_pulse (tmr_pulse_w)
    );

    wdt_pulse_sync #(.STAGES(SYNC_STAGES)) u_to_out (
        .src_clk   (wclk_i),
        .src_rst_n (wrst_n),
        .src_pulse (timeout_w),
        .dst_clk   (clk_i),
        .dst_rst_n (rst_ni),
        .dst_pulse (to_evt_s)
    );

    wdt_pulse_sync #(.STAGES(SYNC_STAGES)) u_tick_out (
        .src_clk   (wclk_i),
        .src_rst_n (wrst_n),
        .src_pulse (tmr_pulse_w),
        .dst_clk   (clk_i),
        .dst_rst_n (rst_ni),
        .dst_pulse (tmr_scaled_s)
    );

    // Turn a time-out into reset or wake-up and maintain the status flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rst_req_o  <= 1'b0;
            wake_req_o <= 1'b0;
            tmo_n_o    <= 1'b1;
        end else begin
            rst_req_o  <= to_evt_s && !in_sleep_i;
            wake_req_o <= to_evt_s && in_sleep_i;
            if (to_evt_s) tmo_n_o <= 1'b0;
            else if (cmd_any) tmo_n_o <= 1'b1;
        end
    end

    // Timer tick: bypass when the scaler belongs to the watchdog.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) tmr_tick_o <= 1'b0;
        else tmr_tick_o <= scl_sel_i ? tmr_src_i : tmr_scaled_s;
    end
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
// Protocol checks for wdt_shared_scaler, attached by bind below.
module wdt_checker (
    input logic clk,
    input logic rst_n,
    input logic wclk,
    input logic wrst_n,
    input logic rst_req,
    input logic wake_req,
    input logic tmo_n,
    input logic in_sleep,
    input logic clr_cmd,
    input logic slp_cmd,
    input logic en_w,
    input logic timeout_w
);
    assert_req_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_req));

    assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_rst_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(in_sleep));

    assert_wake_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(in_sleep));

    assert_wake_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    assert_flag_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> !tmo_n);

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_cmd || slp_cmd) && !rst_req && !wake_req) |-> tmo_n);

    assert_quiet_off_R12: assert property (@(posedge wclk) disable iff (!wrst_n)
        !en_w |-> !timeout_w);
endmodule

bind wdt_shared_scaler wdt_checker u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .wclk      (wclk_i),
    .wrst_n    (wrst_n),
    .rst_req   (rst_req_o),
    .wake_req  (wake_req_o),
    .tmo_n     (tmo_n_o),
    .in_sleep  (in_sleep_i),
    .clr_cmd   (clr_cmd_i),
    .slp_cmd   (slp_cmd_i),
    .en_w      (cfg_en_w),
    .timeout_w (timeout_w)
);

// File: tb/tb_wdt_shared_scaler.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected time-outs, a monitor pops
// and compares them as the design raises reset or wake-up requests.
module tb_wdt_shared_scaler;
    localparam int BASE_W = 4;
    localparam int SCL_W  = 8;
    localparam int BASE_P = 1 << BASE_W;
    localparam int TOL    = 3;

    logic       clk = 1'b0;
    logic       wclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_en = 1'b0;
    logic       scl_sel = 1'b1;
    logic [2:0] scl_ratio = 3'd7;
    logic       in_sleep = 1'b0;
    logic       clr_cmd = 1'b0;
    logic       slp_cmd = 1'b0;
    logic       tmr_src = 1'b0;
    logic       rst_req, wake_req, tmo_n, tmr_tick;

    always #2 clk = ~clk;
    always #6 wclk = ~wclk;

    wdt_shared_scaler #(.BASE_W(BASE_W), .SCL_W(SCL_W)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wclk_i      (wclk),
        .wd_en_i     (wd_en),
        .scl_sel_i   (scl_sel),
        .scl_ratio_i (scl_ratio),
        .in_sleep_i  (in_sleep),
        .clr_cmd_i   (clr_cmd),
        .slp_cmd_i   (slp_cmd),
        .tmr_src_i   (tmr_src),
        .rst_req_o   (rst_req),
        .wake_req_o  (wake_req),
        .tmo_n_o     (tmo_n),
        .tmr_tick_o  (tmr_tick)
    );

    typedef struct {
        bit    wake;
        int    gap;
        string tag;
    } exp_t;

    exp_t expq[$];
    exp_t cur;
    int   errors = 0;
    int   checks = 0;
    int   wcnt = 0;
    int   last_w = 0;
    int   evt_seen = 0;
    int   tick_seen = 0;
    bit   draining = 1'b1;
    bit   done = 1'b0;

    task automatic chk(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge wclk) wcnt++;

    // Monitor: compare each request against the head of the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tmr_tick) tick_seen++;
            if (rst_req || wake_req) begin
                evt_seen++;
                if (!draining) begin
                    if (expq.size() == 0) begin
                        chk("R9 unexpected time-out", 1'b0, 1, 0);
                    end else begin
                        cur = expq.pop_front();
                        chk({cur.tag, " request kind"},
                            (wake_req == cur.wake) && (rst_req != cur.wake),
                            int'(wake_req), int'(cur.wake));
                        if (cur.gap > 0)
                            chk({cur.tag, " interval"},
                                (wcnt - last_w >= cur.gap - TOL) &&
                                (wcnt - last_w <= cur.gap + TOL),
                                wcnt - last_w, cur.gap);
                        chk("R8 flag low on time-out", tmo_n == 1'b0, int'(tmo_n), 0);
                    end
                end
                last_w = wcnt;
            end
        end
    end

    task automatic wait_w(int n);
        repeat (n) @(posedge wclk);
    endtask

    task automatic pulse_cmd(bit slp);
        @(negedge clk);
        if (slp) slp_cmd = 1'b1; else clr_cmd = 1'b1;
        @(negedge clk);
        slp_cmd = 1'b0;
        clr_cmd = 1'b0;
    endtask

    task automatic send_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tmr_src = 1'b1;
            @(negedge clk);
            tmr_src = 1'b0;
            repeat (24) @(negedge clk);
        end
        wait_w(8);
        repeat (4) @(negedge clk);
    endtask

    // Quiesce, apply a configuration, clear, then let the watchdog run.
    task automatic setup(bit sel, int k, bit sleep_mode, bit run);
        draining = 1'b1;
        wd_en = 1'b0;
        wait_w(12);
        scl_sel = sel;
        scl_ratio = 3'(k);
        in_sleep = sleep_mode;
        wait_w(6);
        pulse_cmd(sleep_mode);
        wait_w(8);
        expq.delete();
        draining = 1'b0;
        if (run) wd_en = 1'b1;
    endtask

    // Driver: queue one unchecked first event, then n timed events.
    task automatic expect_run(bit wake, int gap, int n, string tag);
        exp_t e;
        e.wake = wake; e.gap = 0; e.tag = tag;
        expq.push_back(e);
        for (int i = 0; i < n; i++) begin
            e.gap = gap;
            expq.push_back(e);
        end
        for (int i = 0; i < 30000 && expq.size() != 0; i++) @(negedge clk);
        chk({tag, " all expected time-outs seen"}, expq.size() == 0, expq.size(), 0);
        draining = 1'b1;
    endtask

    initial begin
        int base_evt;
        int t0;
        repeat (4) @(negedge clk);
        chk("R1 rst_req in reset", rst_req == 1'b0, int'(rst_req), 0);
        chk("R1 tmo_n in reset", tmo_n == 1'b1, int'(tmo_n), 1);
        repeat (8) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wake_req after reset", wake_req == 1'b0, int'(wake_req), 0);
        chk("R1 tmr_tick after reset", tmr_tick == 1'b0, int'(tmr_tick), 0);
        chk("R1 tmo_n after reset", tmo_n == 1'b1, int'(tmo_n), 1);

        // R2: postscaler on the watchdog, several ratios
        setup(1'b1, 2, 1'b0, 1'b1);
        expect_run(1'b0, BASE_P * 4, 3, "R2 k=2");
        setup(1'b1, 5, 1'b0, 1'b1);
        expect_run(1'b0, BASE_P * 32, 2, "R2 k=5");
        // R6: awake time-out gives reset request
        setup(1'b1, 0, 1'b0, 1'b1);
        expect_run(1'b0, BASE_P, 3, "R6 k=0");
        // R3: scaler lent to the timer, ratio ignored by the watchdog
        setup(1'b0, 6, 1'b0, 1'b1);
        expect_run(1'b0, BASE_P, 3, "R3 k=6");
        // R7: asleep time-out gives wake-up request
        setup(1'b1, 1, 1'b1, 1'b1);
        expect_run(1'b1, BASE_P * 2, 3, "R7 k=1");

        // R8: flag stays low, then a clear sets it
        wd_en = 1'b0;
        in_sleep = 1'b0;
        wait_w(20);
        chk("R8 flag held low", tmo_n == 1'b0, int'(tmo_n), 0);
        pulse_cmd(1'b0);
        @(negedge clk);
        chk("R8 flag set by clear", tmo_n == 1'b1, int'(tmo_n), 1);

        // R9: frequent clears keep the base counter from overflowing
        setup(1'b1, 0, 1'b0, 1'b0);
        base_evt = evt_seen;
        wd_en = 1'b1;
        for (int i = 0; i < 50; i++) begin
            pulse_cmd(1'b0);
            wait_w(8);
        end
        chk("R9 no time-out under clears", evt_seen == base_evt, evt_seen - base_evt, 0);

        // R10: clears also zero the postscaler
        setup(1'b1, 3, 1'b0, 1'b0);
        base_evt = evt_seen;
        wd_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            pulse_cmd(1'b0);
            wait_w(24);
        end
        chk("R10 postscaler cleared", evt_seen == base_evt, evt_seen - base_evt, 0);

        // R12: disabled watchdog never times out
        setup(1'b1, 0, 1'b0, 1'b0);
        base_evt = evt_seen;
        wait_w(400);
        chk("R12 no time-out when disabled", evt_seen == base_evt, evt_seen - base_evt, 0);

        // R4: timer prescale divides by 4 (scaler zeroed first)
        draining = 1'b1;
        scl_sel = 1'b0;
        scl_ratio = 3'd2;
        wait_w(8);
        t0 = tick_seen;
        send_ticks(12);
        chk("R4 prescaled ticks", tick_seen - t0 == 3, tick_seen - t0, 3);

        // R11: a clear does not disturb the timer prescale
        t0 = tick_seen;
        send_ticks(3);
        chk("R11 no tick before fourth", tick_seen - t0 == 0, tick_seen - t0, 0);
        pulse_cmd(1'b0);
        wait_w(8);
        send_ticks(1);
        chk("R11 tick after clear", tick_seen - t0 == 1, tick_seen - t0, 1);

        // R5: bypass when the scaler belongs to the watchdog
        scl_sel = 1'b1;
        wait_w(8);
        t0 = tick_seen;
        send_ticks(5);
        chk("R5 undivided ticks", tick_seen - t0 == 5, tick_seen - t0, 5);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk("watchdog expired", 1'b0, 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule